// File: doc/BRIEF.md
# UART FIFO DMA Ready Signaller

This block produces the two active-low DMA request lines of one UART channel: a transmit-ready request that asks a DMA engine for more characters, and a receive-ready request that asks it to drain received ones. It contains a 16-entry transmit FIFO filled from the CPU side and emptied by a serial-side pop. It also contains a 16-entry receive FIFO filled by a serial-side push and drained by CPU reads. The pop and push stand in for the shift registers. A flag that steers an external data bus transceiver is raised during every CPU read.

Two signalling modes are available. Mode 0 is the single-transfer style, and it applies whenever the FIFOs are off or the mode-select bit is clear. Mode 1 is the multi-transfer style, and it applies only when the FIFOs are on and mode-select is set. In mode 1, the receive request fires at a programmable fill level or after a quiet-line timeout, and it is held until the receive FIFO is empty. With the FIFOs off, each direction acts as a single-character holding register.

The control word is written through a strobe. Its fields are FIFO enable, receive clear, transmit clear, mode select and a 2-bit trigger code. The clears act only in the cycle of the strobe. A character-time tick feeds the receive timeout.

Top module: `uart_dma_ready`

## Requirements
- R1: After reset, the FIFOs are off, both levels are 0, `tx_rdy_n` is 0, `rx_rdy_n` is 1 and `cpu_rdata` is 0.
- R2: With the FIFOs off, each direction holds one character, and a second write or push is dropped. Mode 0 rules apply even when `fcr_dma_sel` is 1.
- R3: In transmit mode 0, `tx_rdy_n` is 0 exactly when the transmit level is 0.
- R4: In transmit mode 1, `tx_rdy_n` is 0 while the transmit level is below 16, and 1 when the level is 16.
- R5: In receive mode 0, `rx_rdy_n` is 0 exactly when the receive level is 1 or more.
- R6: In receive mode 1, `rx_rdy_n` goes to 0 in the cycle after a push brings the level to the trigger. The trigger code maps 0→1, 1→4, 2→8 and 3→14. Once low, it stays low until the level reaches 0.
- R7: In receive mode 1, `rx_rdy_n` also goes to 0 on the 4th `char_tick` seen while the receive FIFO is non-empty with no push and no read. Any push or read restarts that count.
- R8: A control write has these effects:
  - `fcr_rx_clr` empties the receive FIFO.
  - `fcr_tx_clr` empties the transmit FIFO.
  - Changing `fcr_en` empties both FIFOs.
  - A FIFO not cleared keeps its level.
- R9: A CPU write into a full transmit FIFO is discarded. A push into a full receive FIFO is discarded. The level stays at the capacity.
- R10: A CPU read returns the head character on `cpu_rdata` from the next cycle. A read of an empty receive FIFO leaves `cpu_rdata` and the level unchanged.
- R11: `bus_buf_out` is 1 in the same cycle as `cpu_rd` or `cpu_stat_rd`, and 0 otherwise.
- R12: Both FIFOs deliver characters in arrival order. `ser_tx_data` shows the oldest transmit character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fcr_wr | input | 1 | Control word write strobe |
| fcr_en | input | 1 | FIFO enable field |
| fcr_rx_clr | input | 1 | Receive FIFO clear field |
| fcr_tx_clr | input | 1 | Transmit FIFO clear field |
| fcr_dma_sel | input | 1 | DMA mode select field |
| fcr_trig | input | 2 | Receive trigger code |
| cpu_wr | input | 1 | CPU write into transmit FIFO |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU data read from receive FIFO |
| cpu_stat_rd | input | 1 | CPU status read |
| cpu_rdata | output | 8 | Last character read |
| ser_tx_pop | input | 1 | Serial side takes a transmit character |
| ser_tx_data | output | 8 | Oldest transmit character |
| ser_rx_push | input | 1 | Serial side delivers a received character |
| ser_rx_data | input | 8 | Received character |
| char_tick | input | 1 | One pulse per character time |
| tx_level | output | 5 | Transmit FIFO occupancy |
| rx_level | output | 5 | Receive FIFO occupancy |
| tx_rdy_n | output | 1 | Transmit DMA request, active low |
| rx_rdy_n | output | 1 | Receive DMA request, active low |
| bus_buf_out | output | 1 | High during CPU reads |

## Verification
The bench drives the receive request in mode 1 down to a level of one and checks that it stays asserted. A design that released at the trigger level would drop the request early. The timeout is run with a push inserted partway through, which catches a counter that is not restarted and so fires one or more ticks too soon. The bench checks writes and pushes at full capacity, and a read from an empty FIFO, for levels that stay put and read data that does not change. A control write that clears only one FIFO must leave the other intact. With the FIFOs off, the holding register must still use mode 0 rules even with mode select set.

// File: rtl/uart_dma_ready.sv
module uart_dma_ready #(
  parameter int DEPTH     = 16,
  parameter int DW        = 8,
  parameter int TMO_TICKS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fcr_wr,
  input  logic          fcr_en,
  input  logic          fcr_rx_clr,
  input  logic          fcr_tx_clr,
  input  logic          fcr_dma_sel,
  input  logic [1:0]    fcr_trig,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_rd,
  input  logic          cpu_stat_rd,
  output logic [DW-1:0] cpu_rdata,
  input  logic          ser_tx_pop,
  output logic [DW-1:0] ser_tx_data,
  input  logic          ser_rx_push,
  input  logic [DW-1:0] ser_rx_data,
  input  logic          char_tick,
  output logic [$clog2(DEPTH+1)-1:0] tx_level,
  output logic [$clog2(DEPTH+1)-1:0] rx_level,
  output logic          tx_rdy_n,
  output logic          rx_rdy_n,
  output logic          bus_buf_out
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam int TW = $clog2(TMO_TICKS+1);

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt, rx_cnt_nxt, cap, trig_lvl;
  logic [TW-1:0] tmo_q;
  logic [1:0]    trig_q;
  logic          en_q, sel_q, rx_req_q;

  wire mode1  = en_q & sel_q;
  wire toggle = fcr_wr & (fcr_en != en_q);
  wire clr_tx = (fcr_wr & fcr_tx_clr) | toggle;
  wire clr_rx = (fcr_wr & fcr_rx_clr) | toggle;
  wire wr_ok  = cpu_wr & (tx_cnt < cap);
  wire pop_ok = ser_tx_pop & (tx_cnt != '0);
  wire psh_ok = ser_rx_push & (rx_cnt < cap);
  wire rd_ok  = cpu_rd & (rx_cnt != '0);
  wire tmo_hit = char_tick & (rx_cnt != '0) & ~psh_ok & ~rd_ok & ~clr_rx
                 & (tmo_q == TW'(TMO_TICKS-1));

  assign cap = en_q ? CW'(DEPTH) : CW'(1);
  assign rx_cnt_nxt = clr_rx ? '0 : rx_cnt + CW'(psh_ok) - CW'(rd_ok);

  always_comb begin
    case (trig_q)
      2'd0:    trig_lvl = CW'(1);
      2'd1:    trig_lvl = CW'(4);
      2'd2:    trig_lvl = CW'(8);
      default: trig_lvl = CW'(14);
    endcase
  end

  assign tx_level    = tx_cnt;
  assign rx_level    = rx_cnt;
  assign ser_tx_data = tx_mem[tx_rp];
  assign bus_buf_out = cpu_rd | cpu_stat_rd;
  assign tx_rdy_n    = mode1 ? (tx_cnt == CW'(DEPTH)) : (tx_cnt != '0);
  assign rx_rdy_n    = mode1 ? ~rx_req_q : (rx_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      sel_q  <= 1'b0;
      trig_q <= 2'd0;
    end else if (fcr_wr) begin
      en_q   <= fcr_en;
      sel_q  <= fcr_dma_sel;
      trig_q <= fcr_trig;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok)  tx_mem[tx_wp] <= cpu_wdata;
    if (psh_ok) rx_mem[rx_wp] <= ser_rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (clr_tx) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (wr_ok)  tx_wp <= tx_wp + 1'b1;
      if (pop_ok) tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(wr_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      cpu_rdata <= '0;
    end else begin
      rx_cnt <= rx_cnt_nxt;
      if (clr_rx) begin
        rx_wp <= '0; rx_rp <= '0;
      end else begin
        if (psh_ok) rx_wp <= rx_wp + 1'b1;
        if (rd_ok) begin
          rx_rp     <= rx_rp + 1'b1;
          cpu_rdata <= rx_mem[rx_rp];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q    <= '0;
      rx_req_q <= 1'b0;
    end else begin
      if (clr_rx || rx_cnt == '0 || psh_ok || rd_ok) tmo_q <= '0;
      else if (char_tick && tmo_q != TW'(TMO_TICKS)) tmo_q <= tmo_q + 1'b1;
      if (rx_cnt_nxt == '0) rx_req_q <= 1'b0;
      else rx_req_q <= rx_req_q | (rx_cnt_nxt >= trig_lvl) | tmo_hit;
    end
  end

  AST_HOLD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (tx_cnt <= CW'(1) && rx_cnt <= CW'(1))); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !ser_tx_pop && !fcr_wr && tx_cnt == CW'(DEPTH)) |=> tx_cnt == CW'(DEPTH)); // R9
  AST_RX_TRIG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode1 && !fcr_wr && ser_rx_push && !cpu_rd && rx_cnt < CW'(DEPTH)
     && rx_cnt == trig_lvl - CW'(1)) |=> !rx_rdy_n); // R6
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode1 && !rx_rdy_n && rx_cnt > CW'(1) && !fcr_wr) |=> !rx_rdy_n); // R6
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && rx_cnt == '0 && !ser_rx_push && !fcr_wr) |=> ($stable(cpu_rdata) && rx_cnt == '0)); // R10
endmodule

// File: tb/uart_dma_ready_tb_top.sv
`timescale 1ns/1ps
module uart_dma_ready_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fcr_wr = 0, fcr_en = 0, fcr_rx_clr = 0, fcr_tx_clr = 0, fcr_dma_sel = 0;
  logic [1:0] fcr_trig = 0;
  logic cpu_wr = 0, cpu_rd = 0, cpu_stat_rd = 0, ser_tx_pop = 0, ser_rx_push = 0, char_tick = 0;
  logic [7:0] cpu_wdata = 0, ser_rx_data = 0, cpu_rdata, ser_tx_data;
  logic [4:0] tx_level, rx_level;
  logic tx_rdy_n, rx_rdy_n, bus_buf_out;
  int errors = 0, checks = 0;
  logic [7:0] txq[$], rxq[$];

  always #2.5 clk = ~clk;

  uart_dma_ready dut_i (.clk, .rst_n, .fcr_wr, .fcr_en, .fcr_rx_clr, .fcr_tx_clr,
    .fcr_dma_sel, .fcr_trig, .cpu_wr, .cpu_wdata, .cpu_rd, .cpu_stat_rd, .cpu_rdata,
    .ser_tx_pop, .ser_tx_data, .ser_rx_push, .ser_rx_data, .char_tick,
    .tx_level, .rx_level, .tx_rdy_n, .rx_rdy_n, .bus_buf_out);

  // {wr, pop, push, rd, tx_level, rx_level, tx_rdy_n, rx_rdy_n}, FIFO on, mode 0
  localparam logic [15:0] VEC [8] = '{
    {4'b1000, 5'd1, 5'd0, 2'b11},
    {4'b1010, 5'd2, 5'd1, 2'b10},
    {4'b0110, 5'd1, 5'd2, 2'b10},
    {4'b0101, 5'd0, 5'd1, 2'b00},
    {4'b0001, 5'd0, 5'd0, 2'b01},
    {4'b0010, 5'd0, 5'd1, 2'b00},
    {4'b1001, 5'd1, 5'd0, 2'b11},
    {4'b0100, 5'd0, 5'd0, 2'b01}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic fcr(input logic en, input logic rc, input logic tc, input logic sel, input logic [1:0] tr);
    fcr_wr = 1; fcr_en = en; fcr_rx_clr = rc; fcr_tx_clr = tc; fcr_dma_sel = sel; fcr_trig = tr;
    step(); fcr_wr = 0; fcr_rx_clr = 0; fcr_tx_clr = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    cpu_wr = 1; cpu_wdata = d; step(); cpu_wr = 0;
  endtask
  task automatic push(input logic [7:0] d);
    ser_rx_push = 1; ser_rx_data = d; step(); ser_rx_push = 0;
  endtask
  task automatic rd();
    cpu_rd = 1; step(); cpu_rd = 0;
  endtask
  task automatic pop();
    ser_tx_pop = 1; step(); ser_tx_pop = 0;
  endtask
  task automatic tick();
    char_tick = 1; step(); char_tick = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(); step(); rst_n = 1; step();
    check("R1 tx_rdy_n", tx_rdy_n, 0);
    check("R1 rx_rdy_n", rx_rdy_n, 1);
    check("R1 tx_level", tx_level, 0);
    check("R1 rx_level", rx_level, 0);
    check("R1 cpu_rdata", cpu_rdata, 0);

    cpu_stat_rd = 1; #1 check("R11 stat read", bus_buf_out, 1);
    cpu_stat_rd = 0; #1 check("R11 idle", bus_buf_out, 0);
    cpu_rd = 1; #1 check("R11 data read", bus_buf_out, 1);
    cpu_rd = 0; #1;

    fcr(1, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] exp_rd;
      exp_rd = 0;
      {cpu_wr, ser_tx_pop, ser_rx_push, cpu_rd} = VEC[i][15:12];
      cpu_wdata = 8'h10 + 8'(i); ser_rx_data = 8'hA0 + 8'(i);
      if (ser_tx_pop) check("R12 tx head", ser_tx_data, txq.pop_front());
      if (cpu_wr) txq.push_back(cpu_wdata);
      if (ser_rx_push) rxq.push_back(ser_rx_data);
      if (cpu_rd) exp_rd = rxq.pop_front();
      step();
      check("R3 tx level", tx_level, VEC[i][11:7]);
      check("R5 rx level", rx_level, VEC[i][6:2]);
      check("R3 tx_rdy_n", tx_rdy_n, VEC[i][1]);
      check("R5 rx_rdy_n", rx_rdy_n, VEC[i][0]);
      if (cpu_rd) check("R12 rx order", cpu_rdata, exp_rd);
      {cpu_wr, ser_tx_pop, ser_rx_push, cpu_rd} = 4'b0;
    end

    fcr(0, 0, 0, 1, 0);
    wr(8'h55); wr(8'h66);
    check("R2 tx holds one", tx_level, 1);
    check("R2 tx_rdy_n high", tx_rdy_n, 1);
    check("R2 holding data", ser_tx_data, 8'h55);
    pop();
    check("R2 tx_rdy_n after pop", tx_rdy_n, 0);
    push(8'h77); push(8'h88);
    check("R2 rx holds one", rx_level, 1);
    check("R2 mode0 with sel", rx_rdy_n, 0);
    rd();
    check("R10 read data", cpu_rdata, 8'h77);
    check("R2 rx empty", rx_rdy_n, 1);
    rd();
    check("R10 empty read data", cpu_rdata, 8'h77);
    check("R10 empty read level", rx_level, 0);

    fcr(1, 0, 0, 1, 0);
    for (int i = 0; i < 15; i++) wr(8'h20 + 8'(i));
    check("R4 15 entries low", tx_rdy_n, 0);
    wr(8'h2F);
    check("R4 full high", tx_rdy_n, 1);
    wr(8'hEE);
    check("R9 tx full drop", tx_level, 16);
    check("R12 tx head", ser_tx_data, 8'h20);
    pop();
    check("R4 slot free low", tx_rdy_n, 0);
    check("R12 next head", ser_tx_data, 8'h21);
    fcr(1, 0, 1, 1, 0);
    check("R8 tx clear", tx_level, 0);

    fcr(1, 1, 0, 1, 1);
    push(8'h01); push(8'h02); push(8'h03);
    check("R6 below trigger", rx_rdy_n, 1);
    push(8'h04);
    check("R6 at trigger 4", rx_rdy_n, 0);
    rd(); rd(); rd();
    check("R6 held at level 1", rx_rdy_n, 0);
    rd();
    check("R6 release on empty", rx_rdy_n, 1);

    push(8'h30);
    tick(); tick(); tick();
    check("R7 three ticks", rx_rdy_n, 1);
    tick();
    check("R7 fourth tick", rx_rdy_n, 0);
    rd();
    check("R7 release", rx_rdy_n, 1);
    push(8'h31); tick(); tick(); push(8'h32);
    tick(); tick(); tick();
    check("R7 restart after push", rx_rdy_n, 1);
    tick();
    check("R7 fires after restart", rx_rdy_n, 0);

    wr(8'h40);
    fcr(1, 0, 1, 1, 1);
    check("R8 tx cleared", tx_level, 0);
    check("R8 rx kept", rx_level, 2);
    fcr(1, 1, 0, 1, 3);
    check("R8 rx cleared", rx_level, 0);
    for (int i = 0; i < 13; i++) push(8'h50 + 8'(i));
    check("R6 below trigger 14", rx_rdy_n, 1);
    push(8'h5D);
    check("R6 at trigger 14", rx_rdy_n, 0);
    push(8'h5E); push(8'h5F); push(8'h60);
    check("R9 rx full drop", rx_level, 16);
    wr(8'h41);
    fcr(0, 0, 0, 1, 3);
    check("R8 toggle rx", rx_level, 0);
    check("R8 toggle tx", tx_level, 0);
    check("R8 toggle rdy", {tx_rdy_n, rx_rdy_n}, 2'b01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule